// File: doc/BRIEF.md
# Branch Prediction Tracking and Recovery Controller

This block sits between instruction fetch and three external prediction structures: a direction predictor, a branch target buffer and a return-address stack. Fetch presents one control instruction per cycle. In the same cycle the block combines the responses of those structures into a predicted direction and next address. It also records an in-flight entry in an age-ordered queue kept separately for each hardware thread. Each entry is tagged with the instruction's sequence number and carries a checkpoint of the return stack.

Later, the pipeline reports three kinds of event for a thread. A commit drains the oldest entries and trains the direction predictor. A squash discards the youngest entries and undoes their effect on the return stack. A mispredict first squashes, then repairs the faulting branch: it retrains the direction, writes the correct target into the target buffer, and drops the entry. Events are processed one entry per cycle by a shared walker. During a commit walk, fetch may keep inserting predictions. During a squash or a repair, all threads are stalled.

Top module: `bpred_track_ctrl`

## Requirements
- R1: An unconditional instruction takes direction taken without a direction lookup: `dp_uncond_valid` is 1 and `dp_lookup_valid` is 0 in its cycle.
- R2: A conditional instruction takes its direction from `dp_lookup_taken`. A not-taken prediction gives `pred_target = pred_pc + INST_BYTES` (4 by default).
- R3: A taken return gets its target from `rs_top_target`, pops the return stack (`rs_pop_valid`), and does not look up the target buffer. Its entry keeps `rs_top_idx` and `rs_top_target`.
- R4: A taken non-return looks up the target buffer. On a hit the target is `tb_target`. On a miss the prediction becomes not-taken.
- R5: A taken call that is not a return pushes `pred_pc + INST_BYTES` onto the return stack, and its entry is marked as a call.
- R6: Event kind 1 (commit, sequence S) retires entries from the old end, one per cycle, while their sequence number is at most S. Each retired entry drives `dp_train_*` with its PC and its predicted direction.
- R7: Event kind 2 (squash, sequence S) removes entries from the young end, one per cycle, while their sequence number is greater than S. A removed return drives `rs_restore_*` with its checkpoint; a removed call drives `rs_pop_valid`.
- R8: Event kind 3 (mispredict) squashes first. If the thread's queue is then non-empty, its youngest entry is trained with `ev_taken`, its PC and `ev_target` are written through `tb_write_*`, and it is removed. The walk then ends.
- R9: A mispredict that leaves the queue empty after its squash produces no training and no target write.
- R10: `rs_wrong_count` increases by exactly one for each repaired entry that used the return stack, and never changes otherwise.
- R11: Each thread's queue holds DEPTH (16) entries. A full queue raises that thread's `stall` bit, and a prediction presented while its thread is stalled is ignored.
- R12: During a squash or repair walk every `stall` bit is 1. `evt_busy` is 1 during any walk, and events are presented only while it is 0.
- R13: During a commit walk a prediction for the same thread is accepted, and it is retired by that walk if its sequence number is at most S.
- R14: A full queue in one thread does not stall another thread.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_valid | input | 1 | Prediction request from fetch |
| pred_tid | input | TID_W | Thread of the request |
| pred_seq | input | SEQ_W | Sequence number of the instruction |
| pred_pc | input | PC_W | Address of the instruction |
| pred_is_uncond | input | 1 | Instruction is unconditional |
| pred_is_ret | input | 1 | Instruction is a return |
| pred_is_call | input | 1 | Instruction is a call |
| pred_taken | output | 1 | Predicted direction |
| pred_target | output | PC_W | Predicted next address |
| stall | output | THREADS | Per-thread prediction stall |
| ev_valid | input | 1 | Event strobe |
| ev_kind | input | 2 | 1 commit, 2 squash, 3 mispredict |
| ev_tid | input | TID_W | Thread of the event |
| ev_seq | input | SEQ_W | Boundary sequence number |
| ev_taken | input | 1 | Resolved direction (mispredict) |
| ev_target | input | PC_W | Resolved target (mispredict) |
| evt_busy | output | 1 | Walker active |
| dp_lookup_valid | output | 1 | Direction lookup request |
| dp_lookup_pc | output | PC_W | Direction lookup address |
| dp_lookup_taken | input | 1 | Direction lookup answer |
| dp_uncond_valid | output | 1 | Unconditional-branch notice |
| dp_train_valid | output | 1 | Direction training strobe |
| dp_train_pc | output | PC_W | Training address |
| dp_train_taken | output | 1 | Training direction |
| tb_lookup_valid | output | 1 | Target buffer lookup request |
| tb_lookup_pc | output | PC_W | Lookup address |
| tb_lookup_tid | output | TID_W | Lookup thread |
| tb_hit | input | 1 | Lookup hit |
| tb_target | input | PC_W | Lookup target |
| tb_write_valid | output | 1 | Target buffer write strobe |
| tb_write_pc | output | PC_W | Write address |
| tb_write_tid | output | TID_W | Write thread |
| tb_write_target | output | PC_W | Written target |
| rs_tid | output | TID_W | Thread of the return stack operation |
| rs_top_idx | input | RS_IDX_W | Current top index |
| rs_top_target | input | PC_W | Current top value |
| rs_push_valid | output | 1 | Push strobe |
| rs_push_addr | output | PC_W | Pushed return address |
| rs_pop_valid | output | 1 | Pop strobe |
| rs_restore_valid | output | 1 | Restore strobe |
| rs_restore_idx | output | RS_IDX_W | Restored top index |
| rs_restore_target | output | PC_W | Restored top value |
| rs_wrong_count | output | RC_W | Repairs of return-stack predictions |

## Verification
The two functions that can fall in the same cycle are a commit walk draining the old end of a thread's queue and a new prediction entering the young end of that same queue. The bench fills one thread to its depth and confirms that stall is up and that a further request is ignored. It then starts a commit whose boundary covers everything and waits for stall to drop after the first retirement. While the walk is still running, it presents a new prediction on that thread. The scoreboard must see all sixteen older trainings in age order, followed by the training of the newly inserted entry. A lost insert, an overwritten slot or a miscounted occupancy breaks that stream.

// File: rtl/bpt_pkg.sv
`timescale 1ns/1ps
package bpt_pkg;

   typedef enum logic [1:0] {
      WK_IDLE   = 2'd0,
      WK_COMMIT = 2'd1,
      WK_SQUASH = 2'd2,
      WK_FIX    = 2'd3
   } walk_t;

   typedef enum logic [1:0] {
      EV_NONE    = 2'd0,
      EV_COMMIT  = 2'd1,
      EV_SQUASH  = 2'd2,
      EV_MISPRED = 2'd3
   } ev_kind_t;

endpackage

// File: rtl/bpt_pred_path.sv
`timescale 1ns/1ps
module bpt_pred_path #(
   parameter int PC_W       = 32,
   parameter int INST_BYTES = 4
) (
   input  logic            accept,
   input  logic            is_uncond,
   input  logic            is_ret,
   input  logic            is_call,
   input  logic [PC_W-1:0] pc,
   input  logic            dp_taken,
   input  logic            tb_hit,
   input  logic [PC_W-1:0] tb_tgt,
   input  logic [PC_W-1:0] rs_tgt,
   output logic            dp_lookup,
   output logic            dp_uncond,
   output logic            tb_lookup,
   output logic            taken,
   output logic [PC_W-1:0] target,
   output logic            rs_push,
   output logic [PC_W-1:0] rs_push_addr,
   output logic            rs_pop,
   output logic            used_rs,
   output logic            was_call
);
   localparam logic [PC_W-1:0] STEP = PC_W'(INST_BYTES);

   logic            dir;
   logic            take_ret;
   logic            take_tb;
   logic [PC_W-1:0] seq_pc;

   always_comb begin
      dir       = is_uncond | dp_taken;
      take_ret  = dir & is_ret;
      take_tb   = dir & ~is_ret & tb_hit;
      seq_pc    = pc + STEP;
      dp_lookup = accept & ~is_uncond;
      dp_uncond = accept & is_uncond;
      tb_lookup = accept & dir & ~is_ret;
      taken     = accept & (take_ret | take_tb);
      if (take_ret)
         target = rs_tgt;
      else if (take_tb)
         target = tb_tgt;
      else
         target = seq_pc;
      used_rs      = take_ret;
      was_call     = dir & ~is_ret & is_call;
      rs_push      = accept & was_call;
      rs_push_addr = seq_pc;
      rs_pop       = accept & take_ret;
   end
endmodule

// File: rtl/bpt_thread_queue.sv
`timescale 1ns/1ps
module bpt_thread_queue #(
   parameter int DEPTH = 16,
   parameter int ENT_W = 8,
   parameter int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [ENT_W-1:0] push_ent,
   input  logic             pop_old,
   input  logic             pop_young,
   output logic [CNT_W-1:0] count,
   output logic             full,
   output logic             empty,
   output logic [ENT_W-1:0] old_ent,
   output logic [ENT_W-1:0] young_ent
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("bpt_thread_queue: DEPTH must be a power of two of at least 2");
   end
   if (CNT_W < $clog2(DEPTH + 1)) begin : g_bad_cnt
      $error("bpt_thread_queue: CNT_W too narrow for DEPTH");
   end

   logic [ENT_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0] head;
   logic [PTR_W-1:0] tail;
   logic [PTR_W-1:0] tail_m1;

   always_comb begin
      tail_m1   = tail - 1'b1;
      full      = (count == CNT_W'(DEPTH));
      empty     = (count == '0);
      old_ent   = mem[head];
      young_ent = mem[tail_m1];
   end

   always_ff @(posedge clk) begin
      if (push) mem[tail] <= push_ent;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head  <= '0;
         tail  <= '0;
         count <= '0;
      end else begin
         if (pop_old) head <= head + 1'b1;
         if (push)
            tail <= tail + 1'b1;
         else if (pop_young)
            tail <= tail_m1;
         case ({push, pop_old | pop_young})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end
endmodule

// File: rtl/bpt_walker.sv
`timescale 1ns/1ps
module bpt_walker
   import bpt_pkg::*;
#(
   parameter int PC_W     = 32,
   parameter int SEQ_W    = 16,
   parameter int RS_IDX_W = 4,
   parameter int TID_W    = 1,
   parameter int RC_W     = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ev_valid,
   input  logic [1:0]          ev_kind,
   input  logic [TID_W-1:0]    ev_tid,
   input  logic [SEQ_W-1:0]    ev_seq,
   input  logic                ev_taken,
   input  logic [PC_W-1:0]     ev_target,
   input  logic                sel_empty,
   input  logic [SEQ_W-1:0]    old_seq,
   input  logic [PC_W-1:0]     old_pc,
   input  logic                old_taken,
   input  logic [SEQ_W-1:0]    young_seq,
   input  logic [PC_W-1:0]     young_pc,
   input  logic                young_used_rs,
   input  logic                young_was_call,
   input  logic [RS_IDX_W-1:0] young_rs_idx,
   input  logic [PC_W-1:0]     young_rs_tgt,
   output logic [TID_W-1:0]    wtid,
   output logic                busy,
   output logic                block,
   output logic                pop_old,
   output logic                pop_young,
   output logic                train_valid,
   output logic [PC_W-1:0]     train_pc,
   output logic                train_taken,
   output logic                tbw_valid,
   output logic [PC_W-1:0]     tbw_pc,
   output logic [PC_W-1:0]     tbw_target,
   output logic                rs_pop,
   output logic                rs_restore,
   output logic [RS_IDX_W-1:0] rs_restore_idx,
   output logic [PC_W-1:0]     rs_restore_tgt,
   output logic [RC_W-1:0]     wrong_count
);
   walk_t           state;
   walk_t           nxt;
   logic [SEQ_W-1:0] wseq;
   logic            wmis;
   logic            wtaken;
   logic [PC_W-1:0] wtarget;
   logic            start;
   logic            inc;
   ev_kind_t        kind;

   always_comb begin
      kind  = ev_kind_t'(ev_kind);
      start = (state == WK_IDLE) && ev_valid && (kind != EV_NONE);
      busy  = (state != WK_IDLE);
      block = (state == WK_SQUASH) || (state == WK_FIX);
      nxt            = state;
      pop_old        = 1'b0;
      pop_young      = 1'b0;
      train_valid    = 1'b0;
      train_pc       = old_pc;
      train_taken    = old_taken;
      tbw_valid      = 1'b0;
      tbw_pc         = young_pc;
      tbw_target     = wtarget;
      rs_pop         = 1'b0;
      rs_restore     = 1'b0;
      rs_restore_idx = young_rs_idx;
      rs_restore_tgt = young_rs_tgt;
      inc            = 1'b0;
      case (state)
         WK_IDLE: begin
            if (start) nxt = (kind == EV_COMMIT) ? WK_COMMIT : WK_SQUASH;
         end
         WK_COMMIT: begin
            if (!sel_empty && (old_seq <= wseq)) begin
               pop_old     = 1'b1;
               train_valid = 1'b1;
            end else begin
               nxt = WK_IDLE;
            end
         end
         WK_SQUASH: begin
            if (!sel_empty && (young_seq > wseq)) begin
               pop_young  = 1'b1;
               rs_restore = young_used_rs;
               rs_pop     = ~young_used_rs & young_was_call;
            end else begin
               nxt = wmis ? WK_FIX : WK_IDLE;
            end
         end
         WK_FIX: begin
            if (!sel_empty) begin
               pop_young   = 1'b1;
               train_valid = 1'b1;
               train_pc    = young_pc;
               train_taken = wtaken;
               tbw_valid   = 1'b1;
               inc         = young_used_rs;
            end
            nxt = WK_IDLE;
         end
         default: nxt = WK_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state       <= WK_IDLE;
         wtid        <= '0;
         wseq        <= '0;
         wmis        <= 1'b0;
         wtaken      <= 1'b0;
         wtarget     <= '0;
         wrong_count <= '0;
      end else begin
         state <= nxt;
         if (start) begin
            wtid    <= ev_tid;
            wseq    <= ev_seq;
            wmis    <= (kind == EV_MISPRED);
            wtaken  <= ev_taken;
            wtarget <= ev_target;
         end
         if (inc) wrong_count <= wrong_count + 1'b1;
      end
   end
endmodule

// File: rtl/bpred_track_ctrl.sv
`timescale 1ns/1ps
module bpred_track_ctrl #(
   parameter int THREADS    = 2,
   parameter int DEPTH      = 16,
   parameter int PC_W       = 32,
   parameter int SEQ_W      = 16,
   parameter int RS_IDX_W   = 4,
   parameter int INST_BYTES = 4,
   parameter int RC_W       = 16,
   parameter int TID_W      = (THREADS > 1) ? $clog2(THREADS) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                pred_valid,
   input  logic [TID_W-1:0]    pred_tid,
   input  logic [SEQ_W-1:0]    pred_seq,
   input  logic [PC_W-1:0]     pred_pc,
   input  logic                pred_is_uncond,
   input  logic                pred_is_ret,
   input  logic                pred_is_call,
   output logic                pred_taken,
   output logic [PC_W-1:0]     pred_target,
   output logic [THREADS-1:0]  stall,
   input  logic                ev_valid,
   input  logic [1:0]          ev_kind,
   input  logic [TID_W-1:0]    ev_tid,
   input  logic [SEQ_W-1:0]    ev_seq,
   input  logic                ev_taken,
   input  logic [PC_W-1:0]     ev_target,
   output logic                evt_busy,
   output logic                dp_lookup_valid,
   output logic [PC_W-1:0]     dp_lookup_pc,
   input  logic                dp_lookup_taken,
   output logic                dp_uncond_valid,
   output logic                dp_train_valid,
   output logic [PC_W-1:0]     dp_train_pc,
   output logic                dp_train_taken,
   output logic                tb_lookup_valid,
   output logic [PC_W-1:0]     tb_lookup_pc,
   output logic [TID_W-1:0]    tb_lookup_tid,
   input  logic                tb_hit,
   input  logic [PC_W-1:0]     tb_target,
   output logic                tb_write_valid,
   output logic [PC_W-1:0]     tb_write_pc,
   output logic [TID_W-1:0]    tb_write_tid,
   output logic [PC_W-1:0]     tb_write_target,
   output logic [TID_W-1:0]    rs_tid,
   input  logic [RS_IDX_W-1:0] rs_top_idx,
   input  logic [PC_W-1:0]     rs_top_target,
   output logic                rs_push_valid,
   output logic [PC_W-1:0]     rs_push_addr,
   output logic                rs_pop_valid,
   output logic                rs_restore_valid,
   output logic [RS_IDX_W-1:0] rs_restore_idx,
   output logic [PC_W-1:0]     rs_restore_target,
   output logic [RC_W-1:0]     rs_wrong_count
);
   // entry layout, low to high: checkpoint target, checkpoint index,
   // call flag, return-stack flag, direction, pc, sequence number
   localparam int O_IDX  = PC_W;
   localparam int O_CALL = O_IDX + RS_IDX_W;
   localparam int O_URS  = O_CALL + 1;
   localparam int O_TK   = O_URS + 1;
   localparam int O_PC   = O_TK + 1;
   localparam int O_SEQ  = O_PC + PC_W;
   localparam int ENT_W  = O_SEQ + SEQ_W;
   localparam int QC_W   = $clog2(DEPTH + 1);

   if (THREADS < 1 || (1 << TID_W) < THREADS) begin : g_bad_threads
      $error("bpred_track_ctrl: TID_W cannot address THREADS");
   end
   if (INST_BYTES < 1 || PC_W < 2 || SEQ_W < 1 || RS_IDX_W < 1) begin : g_bad_width
      $error("bpred_track_ctrl: illegal width parameter");
   end

   logic                            tid_ok;
   logic                            accept;
   logic                            pp_rs_pop;
   logic                            pp_used_rs;
   logic                            pp_was_call;
   logic [ENT_W-1:0]                new_ent;
   logic [THREADS-1:0]              q_full;
   logic [THREADS-1:0]              q_empty;
   logic [THREADS-1:0][QC_W-1:0]    q_count;
   logic [THREADS-1:0][ENT_W-1:0]   q_old;
   logic [THREADS-1:0][ENT_W-1:0]   q_young;
   logic [ENT_W-1:0]                sel_old;
   logic [ENT_W-1:0]                sel_young;
   logic [TID_W-1:0]                wtid;
   logic                            wk_block;
   logic                            wk_pop_old;
   logic                            wk_pop_young;
   logic                            wk_rs_pop;

   always_comb begin
      tid_ok = (32'(pred_tid) < THREADS);
      stall  = q_full | {THREADS{wk_block}};
      accept = pred_valid & tid_ok & ~(tid_ok ? stall[pred_tid] : 1'b1);
   end

   bpt_pred_path #(
      .PC_W       (PC_W),
      .INST_BYTES (INST_BYTES)
   ) u_pred_path (
      .accept       (accept),
      .is_uncond    (pred_is_uncond),
      .is_ret       (pred_is_ret),
      .is_call      (pred_is_call),
      .pc           (pred_pc),
      .dp_taken     (dp_lookup_taken),
      .tb_hit       (tb_hit),
      .tb_tgt       (tb_target),
      .rs_tgt       (rs_top_target),
      .dp_lookup    (dp_lookup_valid),
      .dp_uncond    (dp_uncond_valid),
      .tb_lookup    (tb_lookup_valid),
      .taken        (pred_taken),
      .target       (pred_target),
      .rs_push      (rs_push_valid),
      .rs_push_addr (rs_push_addr),
      .rs_pop       (pp_rs_pop),
      .used_rs      (pp_used_rs),
      .was_call     (pp_was_call)
   );

   always_comb begin
      dp_lookup_pc  = pred_pc;
      tb_lookup_pc  = pred_pc;
      tb_lookup_tid = pred_tid;
      new_ent = {pred_seq, pred_pc, pred_taken, pp_used_rs, pp_was_call,
                 rs_top_idx, rs_top_target};
   end

   for (genvar t = 0; t < THREADS; t++) begin : g_thread
      bpt_thread_queue #(
         .DEPTH (DEPTH),
         .ENT_W (ENT_W),
         .CNT_W (QC_W)
      ) u_queue (
         .clk       (clk),
         .rst_n     (rst_n),
         .push      (accept && (32'(pred_tid) == t)),
         .push_ent  (new_ent),
         .pop_old   (wk_pop_old && (32'(wtid) == t)),
         .pop_young (wk_pop_young && (32'(wtid) == t)),
         .count     (q_count[t]),
         .full      (q_full[t]),
         .empty     (q_empty[t]),
         .old_ent   (q_old[t]),
         .young_ent (q_young[t])
      );
   end

   always_comb begin
      sel_old   = q_old[0];
      sel_young = q_young[0];
      for (int t = 1; t < THREADS; t++) begin
         if (32'(wtid) == t) begin
            sel_old   = q_old[t];
            sel_young = q_young[t];
         end
      end
   end

   bpt_walker #(
      .PC_W     (PC_W),
      .SEQ_W    (SEQ_W),
      .RS_IDX_W (RS_IDX_W),
      .TID_W    (TID_W),
      .RC_W     (RC_W)
   ) u_walker (
      .clk            (clk),
      .rst_n          (rst_n),
      .ev_valid       (ev_valid),
      .ev_kind        (ev_kind),
      .ev_tid         (ev_tid),
      .ev_seq         (ev_seq),
      .ev_taken       (ev_taken),
      .ev_target      (ev_target),
      .sel_empty      (q_empty[wtid]),
      .old_seq        (sel_old[O_SEQ +: SEQ_W]),
      .old_pc         (sel_old[O_PC +: PC_W]),
      .old_taken      (sel_old[O_TK]),
      .young_seq      (sel_young[O_SEQ +: SEQ_W]),
      .young_pc       (sel_young[O_PC +: PC_W]),
      .young_used_rs  (sel_young[O_URS]),
      .young_was_call (sel_young[O_CALL]),
      .young_rs_idx   (sel_young[O_IDX +: RS_IDX_W]),
      .young_rs_tgt   (sel_young[0 +: PC_W]),
      .wtid           (wtid),
      .busy           (evt_busy),
      .block          (wk_block),
      .pop_old        (wk_pop_old),
      .pop_young      (wk_pop_young),
      .train_valid    (dp_train_valid),
      .train_pc       (dp_train_pc),
      .train_taken    (dp_train_taken),
      .tbw_valid      (tb_write_valid),
      .tbw_pc         (tb_write_pc),
      .tbw_target     (tb_write_target),
      .rs_pop         (wk_rs_pop),
      .rs_restore     (rs_restore_valid),
      .rs_restore_idx (rs_restore_idx),
      .rs_restore_tgt (rs_restore_target),
      .wrong_count    (rs_wrong_count)
   );

   always_comb begin
      tb_write_tid = wtid;
      rs_pop_valid = pp_rs_pop | wk_rs_pop;
      rs_tid       = wk_block ? wtid : pred_tid;
   end
endmodule

// File: rtl/bpt_checker.sv
`timescale 1ns/1ps
module bpt_checker #(
   parameter int THREADS = 2,
   parameter int DEPTH   = 16,
   parameter int QC_W    = 5,
   parameter int RC_W    = 16
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic [THREADS-1:0]           stall,
   input logic                         evt_busy,
   input logic                         dp_lookup_valid,
   input logic                         dp_uncond_valid,
   input logic                         tb_lookup_valid,
   input logic                         tb_hit,
   input logic                         pred_taken,
   input logic                         tb_write_valid,
   input logic                         rs_push_valid,
   input logic                         rs_pop_valid,
   input logic                         rs_restore_valid,
   input logic [RC_W-1:0]              rs_wrong_count,
   input logic [THREADS-1:0][QC_W-1:0] q_count
);
   // R1: a request uses exactly one of the two direction sources
   p_dir_source_r1: assert property (@(posedge clk) disable iff (!rst_n)
      dp_lookup_valid |-> !dp_uncond_valid);

   p_miss_not_taken_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (tb_lookup_valid && !tb_hit) |-> !pred_taken);

   p_one_stack_op_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rs_push_valid, rs_pop_valid, rs_restore_valid}));

   p_fix_ends_walk_r8: assert property (@(posedge clk) disable iff (!rst_n)
      tb_write_valid |=> !evt_busy);

   p_repair_blocks_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (rs_restore_valid || tb_write_valid) |-> (stall == '1 && evt_busy));

   p_wrong_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rs_wrong_count != $past(rs_wrong_count)) |->
         (rs_wrong_count == $past(rs_wrong_count) + 1'b1));

   for (genvar t = 0; t < THREADS; t++) begin : g_thr
      p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
         32'(q_count[t]) <= DEPTH);
      p_full_stalls_r11: assert property (@(posedge clk) disable iff (!rst_n)
         (32'(q_count[t]) == DEPTH) |-> stall[t]);
      p_count_step_r13: assert property (@(posedge clk) disable iff (!rst_n)
         (q_count[t] == $past(q_count[t])) ||
         (q_count[t] == $past(q_count[t]) + 1'b1) ||
         (q_count[t] == $past(q_count[t]) - 1'b1));
   end
endmodule

bind bpred_track_ctrl bpt_checker #(
   .THREADS (THREADS),
   .DEPTH   (DEPTH),
   .QC_W    ($clog2(DEPTH + 1)),
   .RC_W    (RC_W)
) u_bpt_checker (
   .clk              (clk),
   .rst_n            (rst_n),
   .stall            (stall),
   .evt_busy         (evt_busy),
   .dp_lookup_valid  (dp_lookup_valid),
   .dp_uncond_valid  (dp_uncond_valid),
   .tb_lookup_valid  (tb_lookup_valid),
   .tb_hit           (tb_hit),
   .pred_taken       (pred_taken),
   .tb_write_valid   (tb_write_valid),
   .rs_push_valid    (rs_push_valid),
   .rs_pop_valid     (rs_pop_valid),
   .rs_restore_valid (rs_restore_valid),
   .rs_wrong_count   (rs_wrong_count),
   .q_count          (q_count)
);

// File: tb/test_bpred_track_ctrl.sv
`timescale 1ns/1ps
module test_bpred_track_ctrl;
   localparam int CLK_P = 10;
   localparam int K_TRAIN = 0, K_TBW = 1, K_POP = 2, K_RST = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pred_valid = 0, pred_is_uncond = 0, pred_is_ret = 0, pred_is_call = 0;
   logic [0:0]  pred_tid = 0;
   logic [15:0] pred_seq = 0;
   logic [31:0] pred_pc = 0;
   logic        pred_taken;
   logic [31:0] pred_target;
   logic [1:0]  stall;
   logic        ev_valid = 0, ev_taken = 0;
   logic [1:0]  ev_kind = 0;
   logic [0:0]  ev_tid = 0;
   logic [15:0] ev_seq = 0;
   logic [31:0] ev_target = 0;
   logic        evt_busy;
   logic        dp_lookup_valid, dp_uncond_valid, dp_train_valid, dp_train_taken;
   logic [31:0] dp_lookup_pc, dp_train_pc;
   logic        dp_lookup_taken = 0;
   logic        tb_lookup_valid, tb_write_valid;
   logic [31:0] tb_lookup_pc, tb_write_pc, tb_write_target;
   logic [0:0]  tb_lookup_tid, tb_write_tid, rs_tid;
   logic        tb_hit = 0;
   logic [31:0] tb_target = 0;
   logic [3:0]  rs_top_idx = 0;
   logic [31:0] rs_top_target = 0;
   logic        rs_push_valid, rs_pop_valid, rs_restore_valid;
   logic [31:0] rs_push_addr, rs_restore_target;
   logic [3:0]  rs_restore_idx;
   logic [15:0] rs_wrong_count;

   bpred_track_ctrl i_bpred_track_ctrl (.*);

   always #(CLK_P/2) clk = ~clk;

   typedef struct {
      int          kind;
      logic [31:0] a;
      logic [31:0] b;
      string       req;
   } ev_t;
   ev_t exp_q[$];
   int checks = 0;
   int errors = 0;

   task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic expect_ev(int kind, logic [31:0] a, logic [31:0] b, string req);
      ev_t e;
      e.kind = kind; e.a = a; e.b = b; e.req = req;
      exp_q.push_back(e);
   endtask

   task automatic observe(int kind, logic [31:0] a, logic [31:0] b);
      ev_t e;
      if (exp_q.size() == 0) begin
         chk(0, "unexpected event", 32'(kind), 32'hFFFF_FFFF);
      end else begin
         e = exp_q.pop_front();
         chk(e.kind == kind && e.a == a && e.b == b, e.req,
             (32'(kind) << 28) ^ a ^ b, (32'(e.kind) << 28) ^ e.a ^ e.b);
      end
   endtask

   // monitor: scoreboard consumer, samples a quarter period after each edge
   initial begin
      forever begin
         @(posedge clk);
         #(CLK_P/4);
         if (rst_n) begin
            if (dp_train_valid)   observe(K_TRAIN, dp_train_pc, 32'(dp_train_taken));
            if (tb_write_valid)   observe(K_TBW, tb_write_pc, tb_write_target);
            if (rs_pop_valid)     observe(K_POP, 32'(rs_tid), 0);
            if (rs_restore_valid) observe(K_RST, 32'(rs_restore_idx), rs_restore_target);
         end
      end
   end

   task automatic summary();
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   task automatic pred_drive(int tid, int seq, logic [31:0] pc, bit unc, bit ret, bit call,
                             bit dpt, bit hit, logic [31:0] btgt,
                             logic [3:0] ridx, logic [31:0] rtgt);
      @(negedge clk);
      pred_valid = 1; pred_tid = 1'(tid); pred_seq = 16'(seq); pred_pc = pc;
      pred_is_uncond = unc; pred_is_ret = ret; pred_is_call = call;
      dp_lookup_taken = dpt; tb_hit = hit; tb_target = btgt;
      rs_top_idx = ridx; rs_top_target = rtgt;
      #1;
   endtask

   task automatic pred_end();
      @(posedge clk);
      #1 pred_valid = 0;
   endtask

   task automatic send_ev(int kind, int tid, int seq, bit tk, logic [31:0] tgt);
      @(negedge clk);
      ev_valid = 1; ev_kind = 2'(kind); ev_tid = 1'(tid); ev_seq = 16'(seq);
      ev_taken = tk; ev_target = tgt;
      @(posedge clk);
      #1 ev_valid = 0;
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (evt_busy) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      @(negedge clk);
      chk(stall == 2'b00, "reset stall", 32'(stall), 0);
      chk(!evt_busy, "reset busy", 32'(evt_busy), 0);
      chk(rs_wrong_count == 0, "reset R10 counter", 32'(rs_wrong_count), 0);

      // R2 R4: conditional taken with target hit
      pred_drive(0, 1, 32'h100, 0, 0, 0, 1, 1, 32'h200, 0, 0);
      chk(pred_taken && pred_target == 32'h200, "R2 R4 taken hit", pred_target, 32'h200);
      chk(dp_lookup_valid && tb_lookup_valid, "R2 lookups", 32'({dp_lookup_valid, tb_lookup_valid}), 3);
      pred_end();
      // R2: conditional not taken
      pred_drive(0, 2, 32'h104, 0, 0, 0, 0, 1, 32'h900, 0, 0);
      chk(!pred_taken && pred_target == 32'h108, "R2 not taken", pred_target, 32'h108);
      pred_end();
      // R1 R4: unconditional with target miss
      pred_drive(0, 3, 32'h108, 1, 0, 0, 0, 0, 32'h0, 0, 0);
      chk(dp_uncond_valid && !dp_lookup_valid, "R1 uncond notice", 32'({dp_uncond_valid, dp_lookup_valid}), 2);
      chk(!pred_taken && pred_target == 32'h10C, "R4 miss forced", 32'(pred_taken), 0);
      pred_end();
      // R5: call
      pred_drive(0, 4, 32'h10C, 1, 0, 1, 0, 1, 32'h400, 0, 0);
      chk(pred_taken && pred_target == 32'h400, "R5 call target", pred_target, 32'h400);
      chk(rs_push_valid && rs_push_addr == 32'h110, "R5 push addr", rs_push_addr, 32'h110);
      pred_end();
      // R3: return
      pred_drive(0, 5, 32'h400, 1, 1, 0, 0, 1, 32'hDEAD, 4'd3, 32'h110);
      chk(pred_taken && pred_target == 32'h110, "R3 return target", pred_target, 32'h110);
      chk(rs_pop_valid && !tb_lookup_valid, "R3 pop no lookup", 32'({rs_pop_valid, tb_lookup_valid}), 2);
      pred_end();

      // R6: commit up to 2
      expect_ev(K_TRAIN, 32'h100, 1, "R6 commit train 1");
      expect_ev(K_TRAIN, 32'h104, 0, "R6 commit train 2");
      send_ev(1, 0, 2, 0, 0);
      @(negedge clk);
      chk(evt_busy && stall == 2'b00, "R12 commit not blocking", 32'({evt_busy, stall}), 4);
      wait_idle();
      chk(exp_q.size() == 0, "R6 all trains seen", exp_q.size(), 0);

      // R7: squash above 3, return restored then call popped
      expect_ev(K_RST, 3, 32'h110, "R7 restore return");
      expect_ev(K_POP, 0, 0, "R7 pop call");
      send_ev(2, 0, 3, 0, 0);
      @(negedge clk);
      chk(stall == 2'b11 && evt_busy, "R12 squash stalls all", 32'(stall), 3);
      wait_idle();
      chk(exp_q.size() == 0, "R7 all repairs seen", exp_q.size(), 0);

      // R8: mispredict of seq 3
      expect_ev(K_TRAIN, 32'h108, 1, "R8 retrain");
      expect_ev(K_TBW, 32'h108, 32'h500, "R8 target write");
      send_ev(3, 0, 3, 1, 32'h500);
      wait_idle();
      chk(exp_q.size() == 0, "R8 fix seen", exp_q.size(), 0);
      chk(rs_wrong_count == 0, "R10 no change", 32'(rs_wrong_count), 0);

      // R9: queue now empty, mispredict does nothing
      send_ev(3, 0, 10, 1, 32'h777);
      wait_idle();
      chk(exp_q.size() == 0 && !evt_busy, "R9 empty skip", exp_q.size(), 0);

      // R10: repair of a return-stack prediction
      pred_drive(0, 20, 32'h600, 1, 1, 0, 0, 0, 0, 4'd5, 32'h700);
      chk(pred_taken && pred_target == 32'h700, "R3 second return", pred_target, 32'h700);
      pred_end();
      expect_ev(K_TRAIN, 32'h600, 1, "R8 retrain return");
      expect_ev(K_TBW, 32'h600, 32'h800, "R8 write return");
      send_ev(3, 0, 20, 1, 32'h800);
      wait_idle();
      chk(rs_wrong_count == 1, "R10 counted", 32'(rs_wrong_count), 1);

      // R11 R14: fill thread 1
      for (int i = 0; i < 16; i++) begin
         pred_drive(1, 100 + i, 32'h1000 + 32'(4 * i), 0, 0, 0, 0, 0, 0, 0, 0);
         pred_end();
      end
      @(negedge clk);
      chk(stall == 2'b10, "R11 R14 full stalls only thread 1", 32'(stall), 2);
      pred_drive(1, 116, 32'h1FFC, 0, 0, 0, 1, 1, 32'h5000, 0, 0);
      chk(!dp_lookup_valid && !pred_taken, "R11 stalled request ignored", 32'(dp_lookup_valid), 0);
      pred_end();
      pred_drive(0, 30, 32'h2400, 0, 0, 0, 0, 0, 0, 0, 0);
      chk(dp_lookup_valid, "R14 other thread accepted", 32'(dp_lookup_valid), 1);
      pred_end();

      // R13: commit walk with concurrent insert on the same thread
      for (int i = 0; i < 16; i++)
         expect_ev(K_TRAIN, 32'h1000 + 32'(4 * i), 0, "R6 R13 drain order");
      expect_ev(K_TRAIN, 32'h2000, 1, "R13 concurrent insert retired");
      send_ev(1, 1, 200, 0, 0);
      @(negedge clk);
      while (stall[1]) @(negedge clk);
      #1;
      pred_valid = 1; pred_tid = 1; pred_seq = 116; pred_pc = 32'h2000;
      pred_is_uncond = 0; pred_is_ret = 0; pred_is_call = 0;
      dp_lookup_taken = 1; tb_hit = 1; tb_target = 32'h3000;
      #1;
      chk(evt_busy && pred_taken && pred_target == 32'h3000, "R13 predict during commit",
          pred_target, 32'h3000);
      pred_end();
      wait_idle();
      chk(exp_q.size() == 0, "R13 all trains seen", exp_q.size(), 0);
      chk(stall == 2'b00, "R11 stall released", 32'(stall), 0);

      repeat (3) @(negedge clk);
      summary();
      $finish;
   end
endmodule